// File: doc/BRIEF.md
# Table-Driven Scanline Video Fetcher

This block is a video controller that acts as a read master on shared memory. It turns a framebuffer into a stream of 6-bit colour values, and it generates its own horizontal and vertical syncs. Every native picture line is described by a two-byte entry in a line table held in memory. The first byte of the entry is a page, which is the high address byte. The second byte is a horizontal start offset. The block reads the entry first, then reads `PIX_W` pixel bytes from that page. The low address byte of each pixel read is the offset plus the pixel index, and it wraps at 256. A line can therefore scroll sideways, and bytes pushed off one edge come back on the other. Framebuffer data is never copied.

The pixel bytes go into one bank of a two-bank on-chip line buffer. That bank is then shown on four consecutive output scan lines, so pixel memory is read once for every four output lines. The fetch for native line n runs while line n-1 is on screen, using the other bank. The fetch for line 0 runs during vertical blanking.

The memory side is a request/acknowledge address handshake with in-order read responses of any latency. Other units can watch the current output line number and the horizontal and vertical blanking flags.

Top module: `vfetch_top`

## Requirements
- R1: While `rst` is high: `colour_o` is 0, and `de_o`, `hsync_o`, `vsync_o`, `hblank_o` and `mem_req_o` are low. `vblank_o` is high and `line_o` equals `LINES*4`, the first blanking line. After release, the first output cycle is column 0 of that line.
- R2: The fetch of native line n starts with two accepted reads. The first is at `tbl_base_i + 2n` and returns the page. The second is at `tbl_base_i + 2n + 1` and returns the start offset. Both addresses are 16-bit and wrap.
- R3: After both table bytes have returned, the fetch issues `PIX_W` reads in order. Read i goes to address `{page, (offset + i) mod 256}`.
- R4: During the four output lines 4n to 4n+3, active column x shows the low 6 bits of the byte returned for pixel read x of native line n.
- R5: Each frame has exactly `2 + PIX_W` accepted reads per native line and no others.
  - The fetch of line 0 starts at column 0 of the first blanking line.
  - The fetch of line n ≥ 1 starts at column 0 of output line 4(n-1).
  - Every fetch must complete before the first output line of its native line.
- R6: `colour_o` is 0 whenever `de_o` is low.
- R7: A line lasts `PIX_W+H_FP+H_SYNC+H_BP` cycles.
  - On active lines, `de_o` is high for columns below `PIX_W`.
  - `hblank_o` is high for columns `PIX_W` and above.
  - `hsync_o` is high for `H_SYNC` cycles, starting at column `PIX_W+H_FP`.
- R8: A frame lasts `LINES*4+V_FP+V_SYNC+V_BP` lines.
  - `vblank_o` is high on lines at or above `LINES*4`.
  - `vsync_o` is high for `V_SYNC` lines, starting at line `LINES*4+V_FP`.
- R9: `line_o` gives the output line number of the value currently on `colour_o`. Line 0 is the first active line.
- R10: While `mem_req_o` is high and `mem_ack_i` is low, `mem_req_o` and `mem_addr_o` hold. The picture does not depend on acknowledge stalls or on response latency (one cycle or more, in order).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_base_i | input | 16 | Byte address of the line table entry for native line 0 |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | 16 | Read address, held until acknowledged |
| mem_ack_i | input | 1 | Arbiter accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid, responses in request order |
| mem_rdata_i | input | 8 | Read data byte |
| colour_o | output | COLOR_W | Pixel colour, zero outside the active area |
| de_o | output | 1 | Active display area |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| line_o | output | LINE_W | Current output line number |

## Verification
Every display output (`colour_o`, `de_o`, both syncs, both blanking flags and `line_o`) is registered one cycle behind the beam counters. The bench therefore predicts column 0 of the first blanking line for the first cycle after the first clock edge after reset release. It then advances its own beam position once per cycle and samples at each falling edge.

Memory requests are combinational from registered fetch state. An acceptance takes effect on the rising edge where request and acknowledge are both high. A response driven for edge t is consumed at t.

The bench's memory model decides acknowledge and read data half a cycle before each edge. It compares each accepted address with an address scoreboard at that moment. It schedules each response a scene-dependent latency later, in order. Colour values are popped from a pixel scoreboard only in cycles where the bench's own beam model says the area is active.

// File: rtl/vfetch_pkg.sv
`timescale 1ns/1ps
package vfetch_pkg;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_TBL  = 2'd1,
    F_PIX  = 2'd2
  } fetch_state_e;

  // Address of one byte of a line-table entry (hi=0: page, hi=1: offset)
  function automatic logic [15:0] entry_addr(input logic [15:0] base,
                                             input logic [15:0] row,
                                             input logic        hi);
    return base + {row[14:0], 1'b0} + {15'd0, hi};
  endfunction

  // Pixel byte address: page in the high byte, offset+index wrapping in the low byte
  function automatic logic [15:0] pixel_addr(input logic [7:0] page,
                                             input logic [7:0] xoff,
                                             input logic [7:0] idx);
    logic [7:0] lo;
    lo = xoff + idx;
    return {page, lo};
  endfunction

  // True when pos lies in [first, first+len)
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned first,
                                   input int unsigned len);
    return (pos >= first) && (pos < first + len);
  endfunction

endpackage

// File: rtl/vf_timing.sv
`timescale 1ns/1ps
module vf_timing #(
  parameter int H_TOTAL = 224,
  parameter int V_TOTAL = 525,
  parameter int V_START = 480,
  parameter int HW      = 8,
  parameter int VW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);

  logic h_last;
  logic v_last;

  assign h_last = (hcnt == HW'(H_TOTAL - 1));
  assign v_last = (vcnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= VW'(V_START);
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

endmodule

// File: rtl/vf_fetch.sv
`timescale 1ns/1ps
module vf_fetch
  import vfetch_pkg::*;
#(
  parameter int PIX_W  = 160,
  parameter int BUF_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [15:0]       row,
  input  logic [15:0]       tbl_base,
  output logic              mem_req,
  output logic [15:0]       mem_addr,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [BUF_AW-1:0] wr_idx,
  output logic [7:0]        wr_data,
  output logic              busy,
  output logic              done
);

  localparam int CW = $clog2(PIX_W + 1);

  fetch_state_e   state;
  logic [CW-1:0]  issue_cnt;
  logic [CW-1:0]  recv_cnt;
  logic [15:0]    row_q;
  logic [15:0]    base_q;
  logic [7:0]     page_q;
  logic [7:0]     xoff_q;
  logic           bank_q;
  logic           accept;

  // request generation from registered state
  always_comb begin
    mem_req  = 1'b0;
    mem_addr = '0;
    case (state)
      F_TBL: begin
        mem_req  = (issue_cnt < CW'(2));
        mem_addr = entry_addr(base_q, row_q, issue_cnt[0]);
      end
      F_PIX: begin
        mem_req  = (issue_cnt < CW'(PIX_W));
        mem_addr = pixel_addr(page_q, xoff_q, 8'(issue_cnt));
      end
      default: ;
    endcase
  end

  assign accept  = mem_req && mem_ack;
  assign busy    = (state != F_IDLE);
  assign done    = (state == F_PIX) && mem_rvalid && (recv_cnt == CW'(PIX_W - 1));
  assign wr_en   = (state == F_PIX) && mem_rvalid;
  assign wr_bank = bank_q;
  assign wr_idx  = BUF_AW'(recv_cnt);
  assign wr_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= F_IDLE;
      issue_cnt <= '0;
      recv_cnt  <= '0;
      row_q     <= '0;
      base_q    <= '0;
      page_q    <= '0;
      xoff_q    <= '0;
      bank_q    <= 1'b0;
    end else begin
      case (state)
        F_IDLE: begin
          if (start) begin
            state     <= F_TBL;
            issue_cnt <= '0;
            recv_cnt  <= '0;
            row_q     <= row;
            base_q    <= tbl_base;
            bank_q    <= row[0];
          end
        end
        F_TBL: begin
          if (accept) issue_cnt <= issue_cnt + 1'b1;
          if (mem_rvalid) begin
            if (recv_cnt == '0) page_q <= mem_rdata;
            else                xoff_q <= mem_rdata;
            if (recv_cnt == CW'(1)) begin
              state     <= F_PIX;
              issue_cnt <= '0;
              recv_cnt  <= '0;
            end else begin
              recv_cnt <= recv_cnt + 1'b1;
            end
          end
        end
        F_PIX: begin
          if (accept) issue_cnt <= issue_cnt + 1'b1;
          if (mem_rvalid) begin
            recv_cnt <= recv_cnt + 1'b1;
            if (done) state <= F_IDLE;
          end
        end
        default: state <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vf_linebuf.sv
`timescale 1ns/1ps
module vf_linebuf #(
  parameter int DEPTH = 160,
  parameter int DW    = 6,
  parameter int AW    = 8,
  parameter int BANKS = 2
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] bank_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [DW-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(g))) cells[wr_idx] <= wr_data;
    end
    assign bank_q[g] = cells[rd_idx];
  end

  assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/vfetch_top.sv
`timescale 1ns/1ps
module vfetch_top
  import vfetch_pkg::*;
#(
  parameter int PIX_W     = 160,
  parameter int LINES     = 120,
  parameter int QUAD_LOG2 = 2,
  parameter int H_FP      = 16,
  parameter int H_SYNC    = 24,
  parameter int H_BP      = 24,
  parameter int V_FP      = 10,
  parameter int V_SYNC    = 2,
  parameter int V_BP      = 33,
  parameter int COLOR_W   = 6,
  parameter int LINE_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        tbl_base_i,
  output logic               mem_req_o,
  output logic [15:0]        mem_addr_o,
  input  logic               mem_ack_i,
  input  logic               mem_rvalid_i,
  input  logic [7:0]         mem_rdata_i,
  output logic [COLOR_W-1:0] colour_o,
  output logic               de_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               hblank_o,
  output logic               vblank_o,
  output logic [LINE_W-1:0]  line_o
);

  localparam int V_ACT   = LINES << QUAD_LOG2;
  localparam int H_TOTAL = PIX_W + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int BUF_AW  = $clog2(PIX_W);
  localparam logic [LINE_W-1:0] QMASK = LINE_W'((1 << QUAD_LOG2) - 1);

  logic [HW-1:0]     hcnt;
  logic [LINE_W-1:0] vcnt;
  logic [LINE_W-1:0] native_row;
  logic              act_h;
  logic              act_v;
  logic              act;
  logic              quad_head;

  // named internal events (observed by the bound checker)
  logic              disp_line_start;
  logic              fetch_start;
  logic [LINE_W-1:0] fetch_row;
  logic              fetch_busy;
  logic              fetch_done;

  logic              wr_en;
  logic              wr_bank;
  logic [BUF_AW-1:0] wr_idx;
  logic [7:0]        wr_byte;
  logic [BUF_AW-1:0] rd_idx;
  logic [COLOR_W-1:0] rd_colour;

  vf_timing #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .V_START(V_ACT),
    .HW(HW), .VW(LINE_W)
  ) u_timing (
    .clk(clk), .rst(rst), .hcnt(hcnt), .vcnt(vcnt)
  );

  assign native_row      = vcnt >> QUAD_LOG2;
  assign act_h           = (hcnt < HW'(PIX_W));
  assign act_v           = (vcnt < LINE_W'(V_ACT));
  assign act             = act_h && act_v;
  assign quad_head       = ((vcnt & QMASK) == '0);
  assign disp_line_start = (hcnt == '0) && act_v && quad_head;

  // fetch scheduling: line 0 at blanking start, line n+1 when line n begins
  always_comb begin
    fetch_start = 1'b0;
    fetch_row   = '0;
    if (hcnt == '0) begin
      if (vcnt == LINE_W'(V_ACT)) begin
        fetch_start = 1'b1;
      end else if (act_v && quad_head && (native_row < LINE_W'(LINES - 1))) begin
        fetch_start = 1'b1;
        fetch_row   = native_row + 1'b1;
      end
    end
  end

  vf_fetch #(.PIX_W(PIX_W), .BUF_AW(BUF_AW)) u_fetch (
    .clk(clk), .rst(rst),
    .start(fetch_start), .row(16'(fetch_row)), .tbl_base(tbl_base_i),
    .mem_req(mem_req_o), .mem_addr(mem_addr_o), .mem_ack(mem_ack_i),
    .mem_rvalid(mem_rvalid_i), .mem_rdata(mem_rdata_i),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_byte),
    .busy(fetch_busy), .done(fetch_done)
  );

  assign rd_idx = act_h ? BUF_AW'(hcnt) : '0;

  vf_linebuf #(.DEPTH(PIX_W), .DW(COLOR_W), .AW(BUF_AW), .BANKS(2)) u_buf (
    .clk(clk),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_data(wr_byte[COLOR_W-1:0]),
    .rd_bank(native_row[0]), .rd_idx(rd_idx), .rd_data(rd_colour)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      colour_o <= '0;
      de_o     <= 1'b0;
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      hblank_o <= 1'b0;
      vblank_o <= 1'b1;
      line_o   <= LINE_W'(V_ACT);
    end else begin
      colour_o <= act ? rd_colour : '0;
      de_o     <= act;
      hsync_o  <= in_span(32'(hcnt), PIX_W + H_FP, H_SYNC);
      vsync_o  <= in_span(32'(vcnt), V_ACT + V_FP, V_SYNC);
      hblank_o <= !act_h;
      vblank_o <= !act_v;
      line_o   <= vcnt;
    end
  end

endmodule

// File: rtl/vfetch_chk.sv
`timescale 1ns/1ps
module vfetch_chk #(
  parameter int PIX_W   = 160,
  parameter int COLOR_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_req_o,
  input logic               mem_ack_i,
  input logic [15:0]        mem_addr_o,
  input logic [COLOR_W-1:0] colour_o,
  input logic               de_o,
  input logic               hsync_o,
  input logic               hblank_o,
  input logic               vsync_o,
  input logic               vblank_o,
  input logic               fetch_start,
  input logic               fetch_busy,
  input logic               disp_line_start
);

  logic [15:0] acc_cnt;

  always_ff @(posedge clk) begin
    if (rst || fetch_start) acc_cnt <= '0;
    else if (mem_req_o && mem_ack_i) acc_cnt <= acc_cnt + 1'b1;
  end

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r6_black_outside: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (colour_o == '0));

  a_r7_sync_in_blank: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (!hsync_o && !hblank_o && !vblank_o));

  a_r8_vsync_in_vblank: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> vblank_o);

  a_r5_fetch_ready: assert property (@(posedge clk) disable iff (rst)
    disp_line_start |-> !fetch_busy);

  a_r5_req_budget: assert property (@(posedge clk) disable iff (rst)
    acc_cnt <= 16'(PIX_W + 2));

  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !fetch_busy |-> !mem_req_o);

endmodule

bind vfetch_top vfetch_chk #(.PIX_W(PIX_W), .COLOR_W(COLOR_W)) u_chk (
  .clk(clk), .rst(rst),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
  .colour_o(colour_o), .de_o(de_o), .hsync_o(hsync_o), .hblank_o(hblank_o),
  .vsync_o(vsync_o), .vblank_o(vblank_o),
  .fetch_start(fetch_start), .fetch_busy(fetch_busy),
  .disp_line_start(disp_line_start)
);

// File: tb/vfetch_top_test.sv
`timescale 1ns/1ps
module vfetch_top_test;

  localparam int W = 8, NL = 3, QL = 2;
  localparam int HFP = 2, HS = 3, HBP = 3, VFP = 2, VS = 2, VBP = 2;
  localparam int CW = 6, LW = 5;
  localparam int VA = NL << QL;
  localparam int HT = W + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;

  logic clk = 0, rst = 1;
  logic [15:0] tbl_base_i = '0;
  logic mem_ack_i = 0, mem_rvalid_i = 0;
  logic [7:0] mem_rdata_i = '0;
  logic mem_req_o, de_o, hsync_o, vsync_o, hblank_o, vblank_o;
  logic [15:0] mem_addr_o;
  logic [CW-1:0] colour_o;
  logic [LW-1:0] line_o;

  vfetch_top #(.PIX_W(W), .LINES(NL), .QUAD_LOG2(QL), .H_FP(HFP), .H_SYNC(HS),
    .H_BP(HBP), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .COLOR_W(CW), .LINE_W(LW)) uut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int unsigned cyc = 0;
  logic running = 0;
  int bh, bv, lat_base = 1, acc_n = 0;
  int unsigned last_due = 0;
  logic [7:0] mem [0:65535];
  logic [15:0] exp_addr_q[$];
  logic [CW-1:0] exp_col_q[$];
  logic [7:0] rsp_data_q[$];
  int unsigned rsp_due_q[$];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin @(posedge clk); cyc++; end

  // memory model: acknowledge, address scoreboard, in-order delayed responses
  initial forever begin
    int unsigned np, due;
    @(negedge clk);
    np = cyc + 1;
    if (rsp_due_q.size() > 0 && rsp_due_q[0] == np) begin
      mem_rvalid_i = 1; mem_rdata_i = rsp_data_q.pop_front(); void'(rsp_due_q.pop_front());
    end else begin
      mem_rvalid_i = 0; mem_rdata_i = '0;
    end
    mem_ack_i = ((np + lat_base) % 3) != 0;
    if (mem_req_o && mem_ack_i) begin
      if (exp_addr_q.size() == 0)
        check(0, "R5 extra request", int'(mem_addr_o), 0);
      else begin
        logic [15:0] ea;
        ea = exp_addr_q.pop_front();
        check(mem_addr_o == ea, "R2/R3 request address", int'(mem_addr_o), int'(ea));
      end
      due = np + lat_base + (acc_n % 3);
      if (due <= last_due) due = last_due + 1;
      last_due = due;
      rsp_data_q.push_back(mem[mem_addr_o]);
      rsp_due_q.push_back(due);
      acc_n++;
    end
  end

  // monitor: own beam model plus pixel scoreboard
  initial forever begin
    @(negedge clk);
    if (running) begin
      logic e_de, e_hs, e_vs;
      e_de = (bh < W) && (bv < VA);
      e_hs = (bh >= W + HFP) && (bh < W + HFP + HS);
      e_vs = (bv >= VA + VFP) && (bv < VA + VFP + VS);
      check(de_o == e_de, "R7 de", de_o, e_de);
      check(hblank_o == (bh >= W), "R7 hblank", hblank_o, bh >= W);
      check(hsync_o == e_hs, "R7 hsync", hsync_o, e_hs);
      check(vsync_o == e_vs, "R8 vsync", vsync_o, e_vs);
      check(vblank_o == (bv >= VA), "R8 vblank", vblank_o, bv >= VA);
      check(int'(line_o) == bv, "R9 line", int'(line_o), bv);
      if (e_de) begin
        if (exp_col_q.size() == 0) check(0, "R4 pixel queue empty", int'(colour_o), 0);
        else begin
          logic [CW-1:0] ec;
          ec = exp_col_q.pop_front();
          check(colour_o == ec, "R4 colour", int'(colour_o), int'(ec));
        end
      end else
        check(colour_o == '0, "R6 colour blank", int'(colour_o), 0);
      bh++;
      if (bh == HT) begin bh = 0; bv = (bv == VT - 1) ? 0 : bv + 1; end
    end
  end

  task automatic run_scene(input logic [15:0] base, input logic [7:0] pg0, pstep,
                           xo0, xstep, input int lat, input logic [7:0] seed);
    logic [7:0] pg, xo;
    @(negedge clk);
    rst = 1; running = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(colour_o == 0 && !de_o && !hsync_o && !vsync_o && !hblank_o, "R1 reset outputs",
          {colour_o, de_o, hsync_o, vsync_o, hblank_o}, 0);
    check(vblank_o && int'(line_o) == VA, "R1 reset line", int'(line_o), VA);
    check(!mem_req_o, "R1 no request in reset", mem_req_o, 0);
    for (int a = 0; a < 65536; a++)
      mem[a] = (8'(a[15:8]) * 8'd37) ^ (8'(a[7:0]) * 8'd5) ^ seed;
    exp_addr_q.delete(); exp_col_q.delete(); rsp_data_q.delete(); rsp_due_q.delete();
    last_due = 0;
    for (int n = 0; n < NL; n++) begin
      pg = pg0 + 8'(n) * pstep; xo = xo0 + 8'(n) * xstep;
      mem[base + 16'(2 * n)] = pg;
      mem[base + 16'(2 * n + 1)] = xo;
    end
    for (int n = 0; n < NL; n++) begin
      pg = pg0 + 8'(n) * pstep; xo = xo0 + 8'(n) * xstep;
      exp_addr_q.push_back(base + 16'(2 * n));
      exp_addr_q.push_back(base + 16'(2 * n + 1));
      for (int i = 0; i < W; i++) exp_addr_q.push_back({pg, 8'(xo + 8'(i))});
    end
    for (int v = 0; v < VA; v++)
      for (int x = 0; x < W; x++) begin
        logic [7:0] p2, x2;
        p2 = mem[base + 16'(2 * (v >> QL))];
        x2 = mem[base + 16'(2 * (v >> QL) + 1)];
        exp_col_q.push_back(mem[{p2, 8'(x2 + 8'(x))}][CW-1:0]);
      end
    tbl_base_i = base; lat_base = lat;
    bh = 0; bv = VA;
    @(negedge clk) rst = 0;
    @(posedge clk) running = 1;
    repeat (HT * VT) @(negedge clk);
    #1;
    running = 0; rst = 1;
    check(exp_addr_q.size() == 0, "R5 all reads issued", exp_addr_q.size(), 0);
    check(exp_col_q.size() == 0, "R4 all pixels shown", exp_col_q.size(), 0);
  endtask

  initial begin
    run_scene(16'h1200, 8'h30, 8'h01, 8'h00, 8'h00, 1, 8'h11); // plain pages
    run_scene(16'hAB40, 8'h80, 8'h03, 8'hFC, 8'h01, 2, 8'h5A); // R3 offset wrap
    run_scene(16'h00F0, 8'h44, 8'h00, 8'h20, 8'h70, 3, 8'hC3); // shared page, scrolled, R10 latency
    run_scene(16'hFFFA, 8'hC0, 8'h02, 8'hFF, 8'h81, 4, 8'h07); // R2 table near top, R10 latency
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired R5 actual=%0d expected=%0d", cyc, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule